// File: doc/BRIEF.md
# Guarded Comparator Trip Path

This block conditions the digital output of one analog comparator, for example an under-voltage detector, into a trip signal for the trip-zone input of a PWM generator. The raw comparator bit passes through a two-flop synchronizer. A sample-window majority filter then stops a signal that sits near its threshold from chattering. A sticky latch follows, and it sets whenever the filtered value is high. A 2-bit source selector decides which of these four versions appears at the selected-signal output. The trip output carries that version only while the connection to the trip input is enabled.

An arming controller guards the switch from the startup path to the latched path. On an arm request it looks at the live, unlatched filter value in that same cycle. If a fault is present it refuses to arm and raises a fault flag. If no fault is present it moves the selector to the latched path and enables the trip connection one cycle later. The controller never clears the latch. Software that wants a clean arm pulses the latch clear together with the arm request. That clear cannot discard a fault that is live, because a clear is refused while the filter output is high.

Top module: `trip_arm_path`

## Requirements
- R1: After reset `armed`, `arm_fault`, `latched`, `filt_live` and `trip_out` are 0 and `src_sel` is 2.
- R2: Source codes: 0 gives `cmp_raw` directly (no clock), 1 gives the synchronized bit (two clock edges behind `cmp_raw`), 2 gives the filter output, 3 gives the latch; `mux_out` shows the selected source.
- R3: While unarmed, `src_sel` follows `src_cfg` one edge later, except that a `src_cfg` of 3 yields 2; `trip_out` stays 0 whenever `armed` is 0.
- R4: The filter looks at the last N synchronized samples (N = `win_len`, 1 to 32, 0 treated as 1). It goes to 1 when at least T of them are 1 and to 0 when at least T are 0 (T = `agree_thr`, 0 treated as 1). Otherwise it holds. The output lags `cmp_raw` by four edges.
- R5: The latch sets on the edge after the filter output is 1, whatever the source code is, and holds after the filter falls.
- R6: `latch_clr` clears the latch only in a cycle where the filter output is 0; a clear while the filter is 1 leaves the latch set.
- R7: An arm request while unarmed with the filter at 1 raises `arm_fault` on the next edge; `armed` stays 0 and `src_sel` is not 3.
- R8: An arm request while unarmed with the filter at 0 sets `src_sel` to 3 on the next edge and `armed` one edge after that; `arm_fault` clears on that first edge.
- R9: Arming never clears the latch; a latch left set before arming drives `trip_out` to 1 once `armed` is 1.
- R10: A disarm request while armed drops `armed` (and `trip_out`) on the next edge, and `src_sel` returns to 2 on the edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator bit, asynchronous |
| win_len | input | 6 | Filter window N in samples |
| agree_thr | input | 6 | Agreeing samples T needed to change the filter output |
| src_cfg | input | 2 | Source code requested while unarmed |
| latch_clr | input | 1 | Latch clear pulse |
| arm_req | input | 1 | Arm request pulse |
| disarm_req | input | 1 | Disarm request pulse |
| filt_live | output | 1 | Live filter output (unlatched status) |
| latched | output | 1 | Sticky latch state |
| mux_out | output | 1 | Selected source before the connection gate |
| src_sel | output | 2 | Current source code |
| armed | output | 1 | Connection to trip input enabled |
| arm_fault | output | 1 | Last arm request refused because of a live fault |
| trip_out | output | 1 | Trip signal toward the PWM trip input |

## Verification
Two pairs of events can fall in one cycle. The first is a latch clear and a latch set. The bench pulses the clear while the filter is held high and expects the latch to stay set. It then pulses the clear again after the filter falls and expects the latch to drop. The second is an arm request and a latch clear. The bench raises both together with the filter low and checks three things: the latch is 0 on the same edge that moves the source to 3, `trip_out` stays 0 once armed, and a later fault still propagates to `trip_out`.

// File: rtl/trip_pkg.sv
package trip_pkg;
  typedef enum logic [1:0] {
    SEL_RAW   = 2'd0,
    SEL_SYNC  = 2'd1,
    SEL_FILT  = 2'd2,
    SEL_LATCH = 2'd3
  } trip_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SWITCH  = 2'd1,
    ST_ARMED   = 2'd2,
    ST_RESTORE = 2'd3
  } arm_st_e;
endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/trip_filter.sv
module trip_filter #(
  parameter int WIN_MAX = 32,
  localparam int CW = $clog2(WIN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_i,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] agree_thr,
  output logic          filt_o
);
  logic [WIN_MAX-1:0] hist_q;
  logic [WIN_MAX-1:0] win_mask;
  logic [CW-1:0]      win_eff, thr_eff, ones, zeros;
  logic               filt_q, filt_d, filt_en;

  always_comb begin
    if (win_len == '0)                win_eff = CW'(1);
    else if (win_len > CW'(WIN_MAX))  win_eff = CW'(WIN_MAX);
    else                              win_eff = win_len;
    thr_eff = (agree_thr == '0) ? CW'(1) : agree_thr;
    ones = '0;
    for (int i = 0; i < WIN_MAX; i++) begin
      win_mask[i] = (CW'(i) < win_eff);
      ones = ones + CW'(hist_q[i] & win_mask[i]);
    end
    zeros   = win_eff - ones;
    filt_d  = (ones >= thr_eff);
    filt_en = (ones >= thr_eff) || (zeros >= thr_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[WIN_MAX-2:0], smp_i};
      if (filt_en) filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // R4: a window of one sample makes the filter follow the previous sample
  assert_win1_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == CW'(1) && agree_thr == CW'(1)) |=> (filt_q == $past(hist_q[0])));
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  assert_latch_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q);
  assert_clear_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_q);
  assert_hold_noclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q && !clr_i) |=> q_q);
endmodule

// File: rtl/trip_arm_ctl.sv
module trip_arm_ctl
  import trip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       live_i,
  input  logic [1:0] cfg_i,
  input  logic       arm_req,
  input  logic       disarm_req,
  output logic [1:0] sel_o,
  output logic       conn_o,
  output logic       fault_o
);
  arm_st_e   st_q, st_d;
  trip_sel_e sel_q, sel_d;
  logic      conn_q, conn_d, flt_q, flt_d;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    conn_d = conn_q;
    flt_d  = flt_q;
    case (st_q)
      ST_IDLE: begin
        sel_d = (cfg_i == SEL_LATCH) ? SEL_FILT : trip_sel_e'(cfg_i);
        if (arm_req) begin
          if (live_i) begin
            flt_d = 1'b1;
          end else begin
            flt_d = 1'b0;
            sel_d = SEL_LATCH;
            st_d  = ST_SWITCH;
          end
        end
      end
      ST_SWITCH: begin
        if (disarm_req) st_d = ST_RESTORE;
        else begin
          conn_d = 1'b1;
          st_d   = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (disarm_req) begin
          conn_d = 1'b0;
          st_d   = ST_RESTORE;
        end
      end
      ST_RESTORE: begin
        sel_d = SEL_FILT;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= SEL_FILT;
      conn_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      conn_q <= conn_d;
      flt_q  <= flt_d;
    end
  end

  assign sel_o   = sel_q;
  assign conn_o  = conn_q;
  assign fault_o = flt_q;

  assert_conn_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conn_q |-> (sel_q == SEL_LATCH));
  assert_sel_before_conn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_q) |-> ($past(sel_q) == SEL_LATCH));
  assert_idle_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (sel_q != SEL_LATCH && !conn_q));
  assert_fault_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && arm_req && live_i) |=> (flt_q && !conn_q && sel_q != SEL_LATCH));
  assert_disarm_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && disarm_req) |=> (!conn_q ##1 sel_q == SEL_FILT));
endmodule

// File: rtl/trip_arm_path.sv
module trip_arm_path
  import trip_pkg::*;
#(
  parameter int WIN_MAX     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(WIN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_raw,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] agree_thr,
  input  logic [1:0]    src_cfg,
  input  logic          latch_clr,
  input  logic          arm_req,
  input  logic          disarm_req,
  output logic          filt_live,
  output logic          latched,
  output logic          mux_out,
  output logic [1:0]    src_sel,
  output logic          armed,
  output logic          arm_fault,
  output logic          trip_out
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s, sync_bit, filt_bit, latch_bit, conn;
  logic [1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(cmp_raw), .q_o(sync_bit));

  trip_filter #(.WIN_MAX(WIN_MAX)) u_filt (
    .clk(clk), .rst_n(rst_n_s), .smp_i(sync_bit),
    .win_len(win_len), .agree_thr(agree_thr), .filt_o(filt_bit));

  trip_latch u_latch (
    .clk(clk), .rst_n(rst_n_s), .set_i(filt_bit), .clr_i(latch_clr), .q_o(latch_bit));

  trip_arm_ctl u_ctl (
    .clk(clk), .rst_n(rst_n_s), .live_i(filt_bit), .cfg_i(src_cfg),
    .arm_req(arm_req), .disarm_req(disarm_req),
    .sel_o(sel), .conn_o(conn), .fault_o(arm_fault));

  always_comb begin
    case (trip_sel_e'(sel))
      SEL_RAW:  mux_out = cmp_raw;
      SEL_SYNC: mux_out = sync_bit;
      SEL_FILT: mux_out = filt_bit;
      default:  mux_out = latch_bit;
    endcase
  end

  assign trip_out  = conn & mux_out;
  assign filt_live = filt_bit;
  assign latched   = latch_bit;
  assign src_sel   = sel;
  assign armed     = conn;

  assert_latch_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (filt_live && sel != 2'd3) |=> latched);
endmodule

// File: tb/trip_arm_path_test.sv
`timescale 1ns/1ps
module trip_arm_path_test;
  logic       clk, rst_n, cmp_raw, latch_clr, arm_req, disarm_req;
  logic [5:0] win_len, agree_thr;
  logic [1:0] src_cfg, src_sel;
  logic       filt_live, latched, mux_out, armed, arm_fault, trip_out;
  int n_chk, n_fail;

  trip_arm_path uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .win_len(win_len),
    .agree_thr(agree_thr), .src_cfg(src_cfg), .latch_clr(latch_clr),
    .arm_req(arm_req), .disarm_req(disarm_req), .filt_live(filt_live),
    .latched(latched), .mux_out(mux_out), .src_sel(src_sel), .armed(armed),
    .arm_fault(arm_fault), .trip_out(trip_out));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {init level, 8-bit cyclic pattern (msb first), window, threshold, expected filter}
  localparam logic [21:0] VEC [10] = '{
    {1'b0, 8'hFF, 6'd8,  6'd5,  1'b1},
    {1'b0, 8'hAA, 6'd4,  6'd3,  1'b0},
    {1'b1, 8'hAA, 6'd4,  6'd3,  1'b1},
    {1'b0, 8'hEE, 6'd4,  6'd3,  1'b1},
    {1'b1, 8'h11, 6'd4,  6'd3,  1'b0},
    {1'b0, 8'hFF, 6'd1,  6'd1,  1'b1},
    {1'b0, 8'hFE, 6'd32, 6'd32, 1'b0},
    {1'b0, 8'hFE, 6'd32, 6'd28, 1'b1},
    {1'b1, 8'h00, 6'd0,  6'd0,  1'b0},
    {1'b0, 8'hFF, 6'd0,  6'd0,  1'b1}
  };

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_arm(input logic with_clr);
    arm_req = 1'b1; latch_clr = with_clr;
    step();
    arm_req = 1'b0; latch_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cmp_raw = 1'b0; latch_clr = 1'b0; arm_req = 1'b0;
    disarm_req = 1'b0; win_len = 6'd4; agree_thr = 6'd3; src_cfg = 2'd2;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    check(armed == 0 && arm_fault == 0 && latched == 0 && filt_live == 0 && trip_out == 0,
          "R1 flags", {armed, arm_fault, latched, filt_live, trip_out}, 0);
    check(src_sel == 2'd2, "R1 src_sel", src_sel, 2);

    // R4 table of filter windows and thresholds
    for (int i = 0; i < 10; i++) begin
      win_len = VEC[i][12:7]; agree_thr = VEC[i][6:1];
      cmp_raw = VEC[i][21];
      step(48);
      for (int k = 0; k < 64; k++) begin
        cmp_raw = VEC[i][13 + 7 - (k % 8)];
        step();
      end
      check(filt_live == VEC[i][0], $sformatf("R4 vector %0d", i), filt_live, VEC[i][0]);
      check(trip_out == 1'b0, "R3 unarmed trip", trip_out, 0);
    end

    // R2 source codes
    win_len = 6'd1; agree_thr = 6'd1;
    src_cfg = 2'd0; cmp_raw = 1'b0; step(6);
    check(src_sel == 2'd0, "R3 follows cfg 0", src_sel, 0);
    cmp_raw = 1'b1; #1;
    check(mux_out == 1'b1, "R2 raw code high", mux_out, 1);
    cmp_raw = 1'b0; #1;
    check(mux_out == 1'b0, "R2 raw code low", mux_out, 0);
    src_cfg = 2'd1; step(6);
    cmp_raw = 1'b1; step();
    check(mux_out == 1'b0, "R2 sync first edge", mux_out, 0);
    step();
    check(mux_out == 1'b1, "R2 sync second edge", mux_out, 1);
    src_cfg = 2'd3; step(2);
    check(src_sel == 2'd2, "R3 code 3 replaced", src_sel, 2);
    check(mux_out == filt_live, "R2 filter code", mux_out, filt_live);
    check(trip_out == 1'b0, "R3 trip low unarmed", trip_out, 0);

    // R5 / R6 latch behaviour
    src_cfg = 2'd2; cmp_raw = 1'b0; step(6);
    latch_clr = 1'b1; step(); latch_clr = 1'b0;
    check(latched == 1'b0, "R6 clear with filter low", latched, 0);
    cmp_raw = 1'b1; step(3);
    check(filt_live == 1'b0, "R4 latency before fourth edge", filt_live, 0);
    step();
    check(filt_live == 1'b1, "R4 latency fourth edge", filt_live, 1);
    step();
    check(latched == 1'b1, "R5 latch set", latched, 1);
    cmp_raw = 1'b0; step(6);
    check(latched == 1'b1 && filt_live == 1'b0, "R5 latch holds", latched, 1);
    cmp_raw = 1'b1; step(6);
    latch_clr = 1'b1; step(); latch_clr = 1'b0;
    check(latched == 1'b1, "R6 clear refused while filter high", latched, 1);

    // R7 arm refused on live fault
    pulse_arm(1'b0);
    check(arm_fault == 1'b1, "R7 fault raised", arm_fault, 1);
    check(src_sel != 2'd3, "R7 select not latched", src_sel, 2);
    step();
    check(armed == 1'b0, "R7 not armed", armed, 0);

    // R9 arming with stale latch keeps it
    cmp_raw = 1'b0; step(6);
    pulse_arm(1'b0);
    check(src_sel == 2'd3 && armed == 1'b0, "R8 select first", src_sel, 3);
    check(arm_fault == 1'b0, "R8 fault cleared", arm_fault, 0);
    check(trip_out == 1'b0, "R8 no trip before connect", trip_out, 0);
    step();
    check(armed == 1'b1, "R8 connect second edge", armed, 1);
    check(latched == 1'b1 && trip_out == 1'b1, "R9 stale latch trips", trip_out, 1);

    // R10 disarm ordering
    disarm_req = 1'b1; step(); disarm_req = 1'b0;
    check(armed == 1'b0 && trip_out == 1'b0, "R10 connection drops", armed, 0);
    check(src_sel == 2'd3, "R10 select held one edge", src_sel, 3);
    step();
    check(src_sel == 2'd2, "R10 select restored", src_sel, 2);

    // R8 clean arm with clear in the same cycle
    pulse_arm(1'b1);
    check(latched == 1'b0 && src_sel == 2'd3, "R8 clear with arm", latched, 0);
    step();
    check(armed == 1'b1 && trip_out == 1'b0, "R8 armed clean", trip_out, 0);
    cmp_raw = 1'b1; step(4);
    check(trip_out == 1'b0, "R5 trip waits for latch", trip_out, 0);
    step();
    check(trip_out == 1'b1, "R5 fault reaches trip", trip_out, 1);
    cmp_raw = 1'b0; step(6);
    check(trip_out == 1'b1, "R6 trip held latched", trip_out, 1);
    disarm_req = 1'b1; step(); disarm_req = 1'b0; step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule